// File: doc/BRIEF.md
# Serial Audio Frame Port

This block sits on a one-direction, three-wire serial audio chain made of a bit clock, a frame strobe and a data line. Every stage on the chain shares the bit clock and the strobe, while the data line runs from stage to stage: each stage receives a frame from the stage before it and retransmits its own frame to the stage after it. A frame holds 64 bits, which are four 16-bit channel samples sent one after the other, least significant bit first.

All bus lines are brought into the system clock domain through two-flop synchronisers. Every detected rising edge of the bit clock shifts one received bit into a 64-bit receive register and moves the 64-bit transmit register on by one bit. A rising edge of the strobe closes the frame. The received frame is then handed to the core as four parallel samples, together with a one-cycle valid pulse. In the next cycle, which is the same cycle as that pulse, a new outgoing frame is taken from the core over a valid/ready handshake. The receive side has no back-pressure, because the bus cannot be stalled: the samples stay on `rx_data_o` until the next frame replaces them. On the transmit side the block raises `tx_ready_o` for exactly one cycle per frame. The core must already hold `tx_valid_i` with data at that moment. If `tx_valid_i` is low, a silent (all-zero) frame is sent, and the core's data waits for the next frame.

A small control register selects the timing source and the output state. In slave role the block follows the bus clock and strobe. In master role it follows a pair of local timing inputs. In both roles the selected pair is driven out again as pass-through copies. A single control bit enables or disables the data output and both pass-through outputs together. Each of these outputs carries an output-enable signal, and reset leaves all three disabled.

Top module: `sfb_port`

## Requirements
- R1: A frame is 64 bits long. Sample k (k = 0..3) is held at bits [16k+15:16k] of `rx_data_o` and of `tx_data_i`, and the first bit on the wire is bit 0 of sample 0.
- R2: Each detected rising edge of the selected bit clock shifts the synchronised data input into the receive register at its top end, so that after 64 edges the first bit received sits at bit 0.
- R3: `bus_data_o` shows bit 0 of the loaded transmit frame right after the load. After i further bit-clock rising edges it shows bit i.
- R4: On a rising edge of the selected strobe, `rx_data_o` takes the 64 most recently received bits and `rx_valid_o` is high for exactly one cycle. At all other times `rx_data_o` holds its value.
- R5: `tx_ready_o` is high for exactly one cycle per strobe, in the same cycle as `rx_valid_o`. At that clock edge the transmit register loads `tx_data_i` if `tx_valid_i` is high, and otherwise loads all zeros.
- R6: Control bit 4 selects the role. With 0 (slave), the bus clock and strobe inputs drive the timing and the local pair is ignored. With 1 (master), the local pair drives the timing and the bus pair is ignored. `bus_clk_o` and `bus_strobe_o` copy the selected pair after synchronisation.
- R7: With control bit 3 = 0, `bus_data_oe_o`, `bus_clk_oe_o` and `bus_strobe_oe_o` are all 1. With bit 3 = 1 they are all 0. Reset sets bit 3 = 1 and bit 4 = 0, and the enables change only after a control write.
- R8: When a bit-clock rising edge and a strobe rising edge reach the block in the same cycle, the bit is shifted in before the frame is latched. The newly loaded transmit frame still starts at its bit 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_clk_i | input | 1 | Bus bit clock from the chain (asynchronous) |
| bus_strobe_i | input | 1 | Bus frame strobe from the chain (asynchronous) |
| bus_data_i | input | 1 | Serial data from the upstream stage (asynchronous) |
| loc_clk_i | input | 1 | Local bit clock used in master role |
| loc_strobe_i | input | 1 | Local frame strobe used in master role |
| ctrl_we_i | input | 1 | Control register write strobe |
| ctrl_wdata_i | input | 8 | Control write data: bit 4 role, bit 3 output disable |
| rx_data_o | output | 64 | Received frame, four 16-bit samples |
| rx_valid_o | output | 1 | One-cycle pulse when rx_data_o is renewed |
| tx_data_i | input | 64 | Next frame to transmit, four 16-bit samples |
| tx_valid_i | input | 1 | tx_data_i holds a frame |
| tx_ready_o | output | 1 | One-cycle pulse when tx_data_i is taken |
| bus_data_o | output | 1 | Serial data to the downstream stage |
| bus_data_oe_o | output | 1 | Output enable of bus_data_o |
| bus_clk_o | output | 1 | Pass-through bit clock |
| bus_clk_oe_o | output | 1 | Output enable of bus_clk_o |
| bus_strobe_o | output | 1 | Pass-through frame strobe |
| bus_strobe_oe_o | output | 1 | Output enable of bus_strobe_o |

## Verification
The shift of the 64th bit and the frame latch can fall into one system cycle when the bit clock and the strobe rise together on the bus. The bench provokes this by raising both lines at the same instant for the last bit of a frame. Both lines pass through synchronisers of equal depth, so the two edges are detected in the same cycle. The outcome is judged at the ports: `rx_data_o` must hold all 64 bits including the last one, and the next captured outgoing frame must start at its bit 0 with nothing skipped.

// File: rtl/sfb_pkg.sv
package sfb_pkg;
  localparam int CTRL_W          = 8;
  localparam int CTRL_ROLE_BIT   = 4;
  localparam int CTRL_HIZ_BIT    = 3;

  typedef enum logic {
    ROLE_SLAVE  = 1'b0,
    ROLE_MASTER = 1'b1
  } sfb_role_e;

  typedef struct packed {
    sfb_role_e role;
    logic      out_hiz;
  } sfb_ctrl_t;

  localparam sfb_ctrl_t CTRL_RESET = '{role: ROLE_SLAVE, out_hiz: 1'b1};
endpackage

// File: rtl/sfb_sync.sv
module sfb_sync #(
  parameter int WIDTH  = 3,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [STAGES-1:0][WIDTH-1:0] stg_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stg_q[0] <= '0;
    else        stg_q[0] <= d_i;
  end

  for (genvar s = 1; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stg_q[s] <= '0;
      else        stg_q[s] <= stg_q[s-1];
    end
  end

  assign q_o = stg_q[STAGES-1];
endmodule

// File: rtl/sfb_edge.sv
module sfb_edge #(
  parameter int WIDTH = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] lvl_i,
  output logic [WIDTH-1:0] rise_o,
  output logic [WIDTH-1:0] lvl_q_o
);
  logic [WIDTH-1:0] prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= '0;
    else        prev_q <= lvl_i;
  end

  assign rise_o  = lvl_i & ~prev_q;
  assign lvl_q_o = prev_q;
endmodule

// File: rtl/sfb_rx_deser.sv
module sfb_rx_deser #(
  parameter int FRAME_W = 64
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               shift_i,
  input  logic               bit_i,
  input  logic               latch_i,
  output logic [FRAME_W-1:0] frame_o,
  output logic               valid_o
);
  logic [FRAME_W-1:0] sh_q;
  logic [FRAME_W-1:0] sh_next;

  always_comb begin
    sh_next = sh_q;
    if (shift_i) sh_next = {bit_i, sh_q[FRAME_W-1:1]};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q    <= '0;
      frame_o <= '0;
      valid_o <= 1'b0;
    end else begin
      sh_q    <= sh_next;
      valid_o <= latch_i;
      if (latch_i) frame_o <= sh_next;
    end
  end
endmodule

// File: rtl/sfb_tx_ser.sv
module sfb_tx_ser #(
  parameter int FRAME_W = 64
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               shift_i,
  input  logic               load_i,
  input  logic               load_valid_i,
  input  logic [FRAME_W-1:0] load_frame_i,
  output logic               bit_o
);
  logic [FRAME_W-1:0] sh_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q <= '0;
    end else if (load_i) begin
      sh_q <= load_valid_i ? load_frame_i : '0;
    end else if (shift_i) begin
      sh_q <= {1'b0, sh_q[FRAME_W-1:1]};
    end
  end

  assign bit_o = sh_q[0];
endmodule

// File: rtl/sfb_port.sv
module sfb_port #(
  parameter int SAMPLE_W    = 16,
  parameter int NUM_CH      = 4,
  parameter int SYNC_STAGES = 2,
  localparam int FRAME_W    = SAMPLE_W * NUM_CH
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       bus_clk_i,
  input  logic                       bus_strobe_i,
  input  logic                       bus_data_i,
  input  logic                       loc_clk_i,
  input  logic                       loc_strobe_i,
  input  logic                       ctrl_we_i,
  input  logic [sfb_pkg::CTRL_W-1:0] ctrl_wdata_i,
  output logic [FRAME_W-1:0]         rx_data_o,
  output logic                       rx_valid_o,
  input  logic [FRAME_W-1:0]         tx_data_i,
  input  logic                       tx_valid_i,
  output logic                       tx_ready_o,
  output logic                       bus_data_o,
  output logic                       bus_data_oe_o,
  output logic                       bus_clk_o,
  output logic                       bus_clk_oe_o,
  output logic                       bus_strobe_o,
  output logic                       bus_strobe_oe_o
);
  import sfb_pkg::*;

  localparam int LN_CLK = 0;
  localparam int LN_STB = 1;
  localparam int LN_DAT = 2;
  localparam int N_LN   = 3;

  sfb_ctrl_t ctrl_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= CTRL_RESET;
    end else if (ctrl_we_i) begin
      ctrl_q.role    <= sfb_role_e'(ctrl_wdata_i[CTRL_ROLE_BIT]);
      ctrl_q.out_hiz <= ctrl_wdata_i[CTRL_HIZ_BIT];
    end
  end

  // timing source selection ahead of the synchronisers
  logic [N_LN-1:0] raw_ln;
  always_comb begin
    raw_ln[LN_DAT] = bus_data_i;
    if (ctrl_q.role == ROLE_MASTER) begin
      raw_ln[LN_CLK] = loc_clk_i;
      raw_ln[LN_STB] = loc_strobe_i;
    end else begin
      raw_ln[LN_CLK] = bus_clk_i;
      raw_ln[LN_STB] = bus_strobe_i;
    end
  end

  logic [N_LN-1:0] sync_ln;
  sfb_sync #(.WIDTH(N_LN), .STAGES(SYNC_STAGES)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d_i   (raw_ln),
    .q_o   (sync_ln)
  );

  logic [1:0] rise;
  logic [1:0] lvl_q;
  sfb_edge #(.WIDTH(2)) u_edge (
    .clk     (clk),
    .rst_n   (rst_n),
    .lvl_i   (sync_ln[LN_STB:LN_CLK]),
    .rise_o  (rise),
    .lvl_q_o (lvl_q)
  );

  logic bit_edge;
  logic frame_edge;
  assign bit_edge   = rise[LN_CLK];
  assign frame_edge = rise[LN_STB];

  sfb_rx_deser #(.FRAME_W(FRAME_W)) u_rx (
    .clk     (clk),
    .rst_n   (rst_n),
    .shift_i (bit_edge),
    .bit_i   (sync_ln[LN_DAT]),
    .latch_i (frame_edge),
    .frame_o (rx_data_o),
    .valid_o (rx_valid_o)
  );

  // transmit load follows the receive latch by one cycle
  assign tx_ready_o = rx_valid_o;

  sfb_tx_ser #(.FRAME_W(FRAME_W)) u_tx (
    .clk          (clk),
    .rst_n        (rst_n),
    .shift_i      (bit_edge),
    .load_i       (tx_ready_o),
    .load_valid_i (tx_valid_i),
    .load_frame_i (tx_data_i),
    .bit_o        (bus_data_o)
  );

  assign bus_clk_o       = lvl_q[LN_CLK];
  assign bus_strobe_o    = lvl_q[LN_STB];
  assign bus_data_oe_o   = ~ctrl_q.out_hiz;
  assign bus_clk_oe_o    = ~ctrl_q.out_hiz;
  assign bus_strobe_oe_o = ~ctrl_q.out_hiz;
endmodule

// File: rtl/sfb_port_chk.sv
module sfb_port_chk #(
  parameter int FRAME_W = 64
) (
  input logic               clk,
  input logic               rst_n,
  input logic               bit_edge,
  input logic               ctrl_we_i,
  input logic [FRAME_W-1:0] rx_data_o,
  input logic               rx_valid_o,
  input logic [FRAME_W-1:0] tx_data_i,
  input logic               tx_valid_i,
  input logic               tx_ready_o,
  input logic               bus_data_o,
  input logic               bus_data_oe_o
);
  // R4: received samples change only together with the valid pulse
  p_rx_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(rx_data_o) |-> rx_valid_o);

  // R4: valid is a single-cycle pulse
  p_rx_pulse_r4: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid_o |=> !rx_valid_o);

  // R5: ready is a single-cycle pulse
  p_tx_pulse_r5: assert property (@(posedge clk) disable iff (!rst_n)
    tx_ready_o |=> !tx_ready_o);

  // R5: after a load the wire shows bit 0 of the accepted frame or zero
  p_tx_load_r5: assert property (@(posedge clk) disable iff (!rst_n)
    tx_ready_o |=> (bus_data_o == $past(tx_valid_i & tx_data_i[0])));

  // R3: serial output moves only on a bit edge or a load
  p_tx_shift_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(bus_data_o) |-> $past(bit_edge | tx_ready_o));

  // R7: output enables change only after a control write
  p_oe_write_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(bus_data_oe_o) |-> $past(ctrl_we_i));
endmodule

bind sfb_port sfb_port_chk #(.FRAME_W(FRAME_W)) u_sfb_port_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .bit_edge      (bit_edge),
  .ctrl_we_i     (ctrl_we_i),
  .rx_data_o     (rx_data_o),
  .rx_valid_o    (rx_valid_o),
  .tx_data_i     (tx_data_i),
  .tx_valid_i    (tx_valid_i),
  .tx_ready_o    (tx_ready_o),
  .bus_data_o    (bus_data_o),
  .bus_data_oe_o (bus_data_oe_o)
);

// File: tb/test_sfb_port.sv
module test_sfb_port;
  localparam int CLK_PERIOD = 10;
  localparam int HB = 4;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bclk = 1'b0, bstb = 1'b0, bdat = 1'b0;
  logic        lclk = 1'b0, lstb = 1'b0;
  logic        ctrl_we = 1'b0;
  logic [7:0]  ctrl_wd = 8'h00;
  logic [63:0] rx_data;
  logic        rx_valid;
  logic [63:0] tx_data = '0;
  logic        tx_valid = 1'b0;
  logic        tx_ready;
  logic        dat_o, dat_oe, clk_o, clk_oe, stb_o, stb_oe;

  int n_checks = 0;
  int n_errors = 0;
  int n_valid  = 0;
  int n_ready  = 0;
  bit use_local = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  sfb_port i_sfb_port (
    .clk(clk), .rst_n(rst_n),
    .bus_clk_i(bclk), .bus_strobe_i(bstb), .bus_data_i(bdat),
    .loc_clk_i(lclk), .loc_strobe_i(lstb),
    .ctrl_we_i(ctrl_we), .ctrl_wdata_i(ctrl_wd),
    .rx_data_o(rx_data), .rx_valid_o(rx_valid),
    .tx_data_i(tx_data), .tx_valid_i(tx_valid), .tx_ready_o(tx_ready),
    .bus_data_o(dat_o), .bus_data_oe_o(dat_oe),
    .bus_clk_o(clk_o), .bus_clk_oe_o(clk_oe),
    .bus_strobe_o(stb_o), .bus_strobe_oe_o(stb_oe)
  );

  always @(negedge clk) begin
    if (rx_valid) n_valid++;
    if (tx_ready) n_ready++;
  end

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic waitn(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic set_clk(input logic v);
    if (use_local) lclk = v; else bclk = v;
  endtask

  task automatic set_stb(input logic v);
    if (use_local) lstb = v; else bstb = v;
  endtask

  task automatic write_ctrl(input logic [7:0] v);
    @(negedge clk); ctrl_wd = v; ctrl_we = 1'b1;
    @(negedge clk); ctrl_we = 1'b0;
    waitn(1);
  endtask

  task automatic strobe(input logic [63:0] nxt, input logic vld);
    @(negedge clk); tx_data = nxt; tx_valid = vld;
    set_stb(1'b1); waitn(6);
    set_stb(1'b0); waitn(HB);
  endtask

  task automatic shift_bits(input logic [63:0] f, input int n, output logic [63:0] cap);
    cap = '0;
    for (int i = 0; i < n; i++) begin
      cap[i] = dat_o;
      bdat = f[i];
      set_clk(1'b1); waitn(HB);
      set_clk(1'b0); waitn(HB);
    end
  endtask

  task automatic t_reset();
    check("R7 data oe after reset", {63'd0, dat_oe}, 64'd0);
    check("R7 clk/strobe oe after reset", {62'd0, clk_oe, stb_oe}, 64'd0);
    check("R4 rx valid after reset", {63'd0, rx_valid}, 64'd0);
    check("R4 rx data after reset", rx_data, 64'd0);
    write_ctrl(8'h00);
    check("R7 all oe enabled", {61'd0, dat_oe, clk_oe, stb_oe}, 64'd7);
  endtask

  task automatic t_stream();
    logic [63:0] fa = 64'h8001_7FFE_A5A5_0F0F;
    logic [63:0] fb = 64'h1234_5678_9ABC_DEF0;
    logic [63:0] ta = 64'hC3C3_0001_FFFF_8000;
    logic [63:0] tb = 64'h0F1E_2D3C_4B5A_6978;
    logic [63:0] cap;
    int v0, r0;
    v0 = n_valid; r0 = n_ready;
    strobe(ta, 1'b1);
    check("R5 ready one pulse per strobe", 64'(n_ready - r0), 64'd1);
    shift_bits(fa, 64, cap);
    check("R3 transmitted frame A", cap, ta);
    strobe(tb, 1'b1);
    check("R2 received frame A", rx_data, fa);
    check("R1 sample 0 of frame A", {48'd0, rx_data[15:0]}, {48'd0, fa[15:0]});
    check("R1 sample 3 of frame A", {48'd0, rx_data[63:48]}, {48'd0, fa[63:48]});
    check("R4 one valid pulse per strobe", 64'(n_valid - v0), 64'd2);
    shift_bits(fb, 64, cap);
    check("R3 transmitted frame B", cap, tb);
    waitn(3);
    check("R4 rx held between strobes", rx_data, fa);
    strobe(64'hFFFF_FFFF_FFFF_FFFF, 1'b0);
    check("R4 received frame B", rx_data, fb);
    shift_bits(64'h0, 64, cap);
    check("R5 silent frame without valid", cap, 64'd0);
  endtask

  task automatic t_hiz();
    write_ctrl(8'h08);
    check("R7 all oe disabled", {61'd0, dat_oe, clk_oe, stb_oe}, 64'd0);
    write_ctrl(8'h00);
    check("R7 all oe re-enabled", {61'd0, dat_oe, clk_oe, stb_oe}, 64'd7);
  endtask

  task automatic t_master();
    logic [63:0] fd = 64'hDEAD_BEEF_0123_4567;
    logic [63:0] td = 64'h5555_AAAA_3333_CCCD;
    logic [63:0] cap;
    logic hold;
    write_ctrl(8'h10);
    use_local = 1'b1;
    strobe(td, 1'b1);
    hold = dat_o;
    bdat = 1'b0;
    for (int i = 0; i < 3; i++) begin
      bclk = 1'b1; waitn(HB);
      bclk = 1'b0; waitn(HB);
    end
    check("R6 bus clock ignored in master", {63'd0, dat_o}, {63'd0, hold});
    bclk = 1'b1; waitn(HB);
    check("R6 pass clock ignores bus in master", {63'd0, clk_o}, 64'd0);
    bclk = 1'b0;
    lclk = 1'b1; waitn(HB);
    check("R6 pass clock follows local", {63'd0, clk_o}, 64'd1);
    lclk = 1'b0; waitn(HB);
    // that local edge shifted one bit; restart frame cleanly
    strobe(td, 1'b1);
    shift_bits(fd, 64, cap);
    check("R6 transmit on local timing", cap, td);
    strobe(64'd0, 1'b1);
    check("R6 receive on local timing", rx_data, fd);
    use_local = 1'b0;
    write_ctrl(8'h00);
  endtask

  task automatic t_coincide();
    logic [63:0] ff = 64'hF00D_0000_1111_8421;
    logic [63:0] te = 64'h0000_0000_0000_FFFF;
    logic [63:0] tg = 64'h9C9C_3E3E_7171_0203;
    logic [63:0] cap;
    strobe(te, 1'b1);
    shift_bits(ff, 63, cap);
    check("R3 first 63 bits of frame E", {1'b0, cap[62:0]}, {1'b0, te[62:0]});
    @(negedge clk);
    tx_data = tg; tx_valid = 1'b1;
    bdat = ff[63]; bclk = 1'b1; bstb = 1'b1;
    waitn(6);
    bclk = 1'b0; bstb = 1'b0; waitn(HB);
    check("R8 last bit shifted before latch", rx_data, ff);
    check("R8 new frame starts at bit 0", {63'd0, dat_o}, {63'd0, tg[0]});
    shift_bits(64'h0, 64, cap);
    check("R8 full new frame transmitted", cap, tg);
  endtask

  initial begin
    waitn(3);
    rst_n = 1'b1;
    waitn(2);
    t_reset();
    t_stream();
    t_hiz();
    t_master();
    t_coincide();
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_checks++;
    n_errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
    $finish;
  end
endmodule